// File: doc/BRIEF.md
# Mode-Selectable General-Purpose I/O Port

This block is one byte-wide general-purpose I/O port. Software sets each pin to one of four modes by writing two registers, a mode-select byte and a level byte. The pad logic combines bit i of both bytes into pin i's behaviour. A third register address returns the pin levels after a two-flop synchronizer. The fourth address reads as zero. The port drives three vectors toward its pads: output enable, output level and weak pull-up enable.

The port can be built as a special-function variant (parameter `SPECIAL` = 1). In this variant, writing a one to level bit 7 sends a one-cycle halt request, and writing a one to level bit 6 sends a one-cycle idle request. These two bits are never stored and always read back as zero. Mode-select bits 6 and 7 are stored as usual, but they do not control pins 6 and 7. Bit 6 instead chooses the alternate serial-clock phase, and bit 7 enables the start-up delay after halt.

Register reads go through a two-state access machine with states `RD_IDLE` and `RD_RESP`. A read strobe moves it to `RD_RESP`, which presents the captured byte for one cycle. A strobe seen while in `RD_RESP` keeps it in `RD_RESP`. With no strobe it returns to `RD_IDLE`. Power requests come from a three-state machine with states `PM_RUN`, `PM_HALT` and `PM_IDLE`. A write of level bit 7 enters `PM_HALT` from any state. A write of bit 6 alone enters `PM_IDLE`. Any other cycle returns the machine to `PM_RUN`.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset, the mode-select and level registers both read 0x00, every pad has output enable 0 and pull-up 0, and `halt_req`, `idle_req` and `rd_valid` are all 0.
- R2: Each pin's mode comes from {mode bit, level bit}:
  - 00 is a floating input (oe=0, pu=0, out=0).
  - 01 is an input with pull-up (oe=0, pu=1, out=0).
  - 10 drives low (oe=1, pu=0, out=0).
  - 11 drives high (oe=1, pu=0, out=1).
- R3: The register addresses are: 0 = mode-select, 1 = level, 2 = synchronized pin levels, 3 = reserved and reads 0x00. A write to address 2 or 3 changes no register and no pad output.
- R4: A read strobe sampled at a clock edge gives `rd_data` together with `rd_valid` = 1 for exactly the following cycle. `rd_valid` stays 0 when no read was strobed.
- R5: A pin-read sampled at the second edge after an input change still returns the old level. A pin-read sampled at the third or a later edge returns the new level.
- R6 (special variant): Level bits 6 and 7 always read as 0. Pins 6 and 7 are always floating inputs with no pull-up, whatever is written.
- R7 (special variant): Writing level bit 7 = 1 raises `halt_req` for exactly the one cycle after the write edge.
- R8 (special variant): Writing level bit 6 = 1 with bit 7 = 0 raises `idle_req` for exactly one cycle after the write edge. If both bits are 1, only `halt_req` pulses.
- R9 (special variant): Mode-select bits 6 and 7 are stored and read back unchanged, and they appear on `sclk_alt_phase` (bit 6) and `halt_delay_en` (bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| pin_in | input | 8 | Raw pin levels from the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| halt_req | output | 1 | One-cycle halt request |
| idle_req | output | 1 | One-cycle idle request |
| sclk_alt_phase | output | 1 | Alternate serial-clock phase select |
| halt_delay_en | output | 1 | Start-up delay after halt enable |

## Verification
The results arrive at these times:
- Pad outputs and the two mode-select side outputs change in the cycle right after the write edge.
- `halt_req` and `idle_req` are high only in that same cycle.
- A read answer appears one cycle after its strobe edge.
- A pin change reaches the read path only after two edges.

The bench samples on the falling edge. It checks pads and power pulses at the first falling edge after the write edge, and it checks the pulse end one falling edge later. Every read pushes its expected byte into a queue, and a monitor pops one entry each time `rd_valid` is high. The synchronizer depth is tested with one read that must still see the old pin level, followed by one that must see the new level.

// File: rtl/gpm_pkg.sv
`timescale 1ns/1ps
package gpm_pkg;
    typedef enum logic [1:0] {
        ADR_CFG = 2'd0,
        ADR_DAT = 2'd1,
        ADR_PIN = 2'd2,
        ADR_RSV = 2'd3
    } gpm_addr_e;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_HALT = 2'd1,
        PM_IDLE = 2'd2
    } pm_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    typedef enum logic [1:0] {
        PIN_FLOAT  = 2'b00,
        PIN_PULLUP = 2'b01,
        PIN_LOW    = 2'b10,
        PIN_HIGH   = 2'b11
    } pin_mode_e;

    localparam int HALT_BIT = 7;
    localparam int IDLE_BIT = 6;
endpackage

// File: rtl/gpm_regs.sv
`timescale 1ns/1ps
module gpm_regs
    import gpm_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit SPECIAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             dat_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] cfg_q,
    output logic [WIDTH-1:0] dat_q
);
    localparam logic [WIDTH-1:0] SPC_BITS = WIDTH'(2'b11) << IDLE_BIT;
    localparam logic [WIDTH-1:0] DAT_KEEP = SPECIAL ? ~SPC_BITS : {WIDTH{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dat_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= wdata;
            if (dat_we) dat_q <= wdata & DAT_KEEP;
        end
    end
endmodule

// File: rtl/gpm_pad_ctrl.sv
`timescale 1ns/1ps
module gpm_pad_ctrl
    import gpm_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit SPECIAL = 1'b1
) (
    input  logic [WIDTH-1:0] cfg_q,
    input  logic [WIDTH-1:0] dat_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : gen_pin
        if (SPECIAL && (i == IDLE_BIT || i == HALT_BIT)) begin : gen_fixed
            assign pad_oe[i]  = 1'b0;
            assign pad_out[i] = 1'b0;
            assign pad_pu[i]  = 1'b0;
        end else begin : gen_mode
            pin_mode_e mode;
            assign mode = pin_mode_e'({cfg_q[i], dat_q[i]});
            always_comb begin
                pad_oe[i]  = 1'b0;
                pad_out[i] = 1'b0;
                pad_pu[i]  = 1'b0;
                unique case (mode)
                    PIN_FLOAT:  ;
                    PIN_PULLUP: pad_pu[i] = 1'b1;
                    PIN_LOW:    pad_oe[i] = 1'b1;
                    PIN_HIGH: begin
                        pad_oe[i]  = 1'b1;
                        pad_out[i] = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpm_sync.sv
`timescale 1ns/1ps
module gpm_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpm_pwr_fsm.sv
`timescale 1ns/1ps
module gpm_pwr_fsm
    import gpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_we,
    input  logic halt_bit,
    input  logic idle_bit,
    output logic halt_req,
    output logic idle_req
);
    pm_state_e state_q, state_d;

    always_comb begin
        state_d = PM_RUN;
        unique case (state_q)
            PM_RUN, PM_HALT, PM_IDLE: begin
                if (req_we && halt_bit)      state_d = PM_HALT;
                else if (req_we && idle_bit) state_d = PM_IDLE;
                else                         state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        halt_req = 1'b0;
        idle_req = 1'b0;
        unique case (state_q)
            PM_RUN:  ;
            PM_HALT: halt_req = 1'b1;
            PM_IDLE: idle_req = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_mode_port.sv
`timescale 1ns/1ps
module gpio_mode_port
    import gpm_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit SPECIAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu,
    output logic             halt_req,
    output logic             idle_req,
    output logic             sclk_alt_phase,
    output logic             halt_delay_en
);
    gpm_addr_e        adr;
    logic             cfg_we, dat_we;
    logic [WIDTH-1:0] cfg_q, dat_q, pin_sync, rd_mux;
    rd_state_e        rd_q, rd_d;

    assign adr    = gpm_addr_e'(addr);
    assign cfg_we = wr_en && (adr == ADR_CFG);
    assign dat_we = wr_en && (adr == ADR_DAT);

    gpm_regs #(.WIDTH(WIDTH), .SPECIAL(SPECIAL)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .dat_we(dat_we),
        .wdata(wdata), .cfg_q(cfg_q), .dat_q(dat_q)
    );

    gpm_pad_ctrl #(.WIDTH(WIDTH), .SPECIAL(SPECIAL)) pads_i (
        .cfg_q(cfg_q), .dat_q(dat_q),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    gpm_sync #(.WIDTH(WIDTH)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    if (SPECIAL) begin : gen_special
        gpm_pwr_fsm pwr_i (
            .clk(clk), .rst_n(rst_n), .req_we(dat_we),
            .halt_bit(wdata[HALT_BIT]), .idle_bit(wdata[IDLE_BIT]),
            .halt_req(halt_req), .idle_req(idle_req)
        );
        assign sclk_alt_phase = cfg_q[IDLE_BIT];
        assign halt_delay_en  = cfg_q[HALT_BIT];
    end else begin : gen_plain
        assign halt_req       = 1'b0;
        assign idle_req       = 1'b0;
        assign sclk_alt_phase = 1'b0;
        assign halt_delay_en  = 1'b0;
    end

    always_comb begin
        rd_mux = '0;
        unique case (adr)
            ADR_CFG: rd_mux = cfg_q;
            ADR_DAT: rd_mux = dat_q;
            ADR_PIN: rd_mux = pin_sync;
            ADR_RSV: rd_mux = '0;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        rd_d = RD_IDLE;
        unique case (rd_q)
            RD_IDLE: rd_d = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: rd_d = rd_en ? RD_RESP : RD_IDLE;
            default: rd_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= RD_IDLE;
        else        rd_q <= rd_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    always_comb begin
        rd_valid = 1'b0;
        unique case (rd_q)
            RD_IDLE: rd_valid = 1'b0;
            RD_RESP: rd_valid = 1'b1;
            default: rd_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpm_chk.sv
`timescale 1ns/1ps
module gpm_chk #(
    parameter int WIDTH   = 8,
    parameter bit SPECIAL = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [1:0]       addr,
    input logic [WIDTH-1:0] wdata,
    input logic             rd_valid,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_pu,
    input logic             halt_req,
    input logic             idle_req
);
    // R4
    rd_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

    // R7
    halt_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(wr_en && addr == 2'd1 && wdata[7]));

    // R8
    idle_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |-> $past(wr_en && addr == 2'd1 && wdata[6] && !wdata[7]));

    // R8
    single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_req && idle_req));

    // R2
    drive_or_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_pu) == '0) && ((pad_out & ~pad_oe) == '0));

    // R6
    special_pins_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SPECIAL |-> (pad_oe[7:6] == 2'b00 && pad_pu[7:6] == 2'b00));
endmodule

bind gpio_mode_port gpm_chk #(.WIDTH(WIDTH), .SPECIAL(SPECIAL)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_valid(rd_valid), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .halt_req(halt_req), .idle_req(idle_req)
);

// File: tb/gpio_mode_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mode_port_tb_top;
    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00, pin_in = 8'h00;
    logic [7:0] rd_data, pad_oe, pad_out, pad_pu;
    logic       rd_valid, halt_req, idle_req, sclk_alt_phase, halt_delay_en;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    gpio_mode_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .halt_req(halt_req), .idle_req(idle_req),
        .sclk_alt_phase(sclk_alt_phase), .halt_delay_en(halt_delay_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: pops one expected item per read response
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R4 unexpected rd_valid", rd_data, 8'h00);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(rd_data === it.exp, it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic do_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        sb_q.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_pads(input logic [7:0] cfg, input logic [7:0] dat, input string tag);
        logic [7:0] m;
        m = 8'h3F;
        chk(pad_oe === (cfg & m), {tag, " oe"}, pad_oe, cfg & m);
        chk(pad_pu === (~cfg & dat & m), {tag, " pu"}, pad_pu, ~cfg & dat & m);
        chk(pad_out === (cfg & dat & m), {tag, " out"}, pad_out, cfg & dat & m);
    endtask

    task automatic pulse(input logic [7:0] d, input bit eh, input bit ei, input string tag);
        do_write(2'd1, d);
        chk(halt_req === eh, {tag, " halt"}, {7'd0, halt_req}, {7'd0, eh});
        chk(idle_req === ei, {tag, " idle"}, {7'd0, idle_req}, {7'd0, ei});
        @(negedge clk);
        chk(halt_req === 1'b0 && idle_req === 1'b0, {tag, " pulse end"},
            {6'd0, halt_req, idle_req}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 8'h00, 8'h00);
        finish_run();
    end

    initial begin
        logic [7:0] cfgs [3];
        logic [7:0] dats [3];
        cfgs = '{8'h33, 8'hFF, 8'h0C};
        dats = '{8'h25, 8'hAA, 8'hFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pad_oe === 8'h00 && pad_pu === 8'h00, "R1 pads after reset", pad_oe | pad_pu, 8'h00);
        chk(!halt_req && !idle_req && !rd_valid, "R1 strobes after reset",
            {5'd0, halt_req, idle_req, rd_valid}, 8'h00);
        do_read(2'd0, 8'h00, "R1 mode reg reset");
        do_read(2'd1, 8'h00, "R1 level reg reset");
        @(negedge clk);
        chk(rd_valid === 1'b0, "R4 rd_valid drops", {7'd0, rd_valid}, 8'h00);

        // R2 mode table over several patterns, R6 and R9 for the special bits
        for (int k = 0; k < 3; k++) begin
            do_write(2'd0, cfgs[k]);
            do_write(2'd1, dats[k] & 8'h3F);
            chk_pads(cfgs[k], dats[k], "R2 mode decode");
            chk(sclk_alt_phase === cfgs[k][6] && halt_delay_en === cfgs[k][7], "R9 side outputs",
                {6'd0, halt_delay_en, sclk_alt_phase}, {6'd0, cfgs[k][7], cfgs[k][6]});
            do_read(2'd0, cfgs[k], "R9 mode reg readback");
            do_read(2'd1, dats[k] & 8'h3F, "R6 level readback");
        end

        // R3 writes to pin and reserved addresses ignored (state: cfg 0C, dat 3F)
        do_write(2'd2, 8'hFF);
        do_write(2'd3, 8'hA5);
        chk_pads(8'h0C, 8'h3F, "R3 pads after ignored write");
        do_read(2'd0, 8'h0C, "R3 mode reg unchanged");
        do_read(2'd1, 8'h3F, "R3 level reg unchanged");
        do_read(2'd3, 8'h00, "R3 reserved reads zero");

        // R5 synchronizer depth
        @(negedge clk);
        pin_in = 8'hA5;
        do_read(2'd2, 8'h00, "R5 old level at second edge");
        do_read(2'd2, 8'hA5, "R5 new level later");
        pin_in = 8'h5A;
        do_read(2'd2, 8'hA5, "R5 old level at second edge");
        do_read(2'd2, 8'h5A, "R5 new level later");

        // R6 level bits 6/7 not stored, pins 6/7 float
        do_write(2'd0, 8'hFF);
        pulse(8'hFF, 1'b1, 1'b0, "R8 both bits halt wins");
        chk_pads(8'hFF, 8'hFF, "R6 pins 6/7 float");
        do_read(2'd1, 8'h3F, "R6 bits 6/7 read zero");

        // R7 halt, R8 idle
        pulse(8'h80, 1'b1, 1'b0, "R7 halt pulse");
        pulse(8'h40, 1'b0, 1'b1, "R8 idle pulse");
        pulse(8'h01, 1'b0, 1'b0, "R7 no request");
        do_write(2'd0, 8'h80);
        chk(halt_req === 1'b0, "R7 mode write no halt", {7'd0, halt_req}, 8'h00);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R4 all reads answered", 8'(sb_q.size()), 8'h00);
        finish_run();
    end
endmodule